// File: doc/BRIEF.md
# Watchdog Timer with Guarded Disable

This block is a watchdog for a microcontroller-class system. A free-running counter advances on each cycle in which a slow time-base strobe is high. It raises a one-cycle system-reset request when the count reaches a time-out picked by a 3-bit code. Software keeps the system alive by pulsing a kick input, which clears the count.

The control register is written through a simple write strobe and data byte, and it can be read back at any time. Turning the watchdog on takes a single write. Turning it off takes two writes. The first write sets an unlock bit together with the enable bit. Within the next four clock cycles, a second write clears the enable bit. The unlock bit drops by itself after four cycles, so a lone stray write can never stop the watchdog.

Top module: `wdt_core`

## Requirements
- R1: After reset, the control read-back is 8'h00 and the reset request output is low.
- R2: With the watchdog enabled, the reset request rises 2^(BASE_LOG2+code) strobe cycles after the count starts from zero, where code is read-back bits [2:0]. With the default BASE_LOG2=14, codes 0 to 7 select 16K, 32K, 64K, 128K, 256K, 512K, 1024K and 2048K strobes. Cycles with the strobe low do not advance the count.
- R3: A kick clears the count. A kick in the same cycle as the terminal strobe suppresses the reset request, and a full period restarts from that kick.
- R4: The reset request lasts exactly one cycle, and the count restarts from zero, so the next request comes one full period later.
- R5: While the watchdog is disabled (bit 3 low), the count is held at zero and no reset request is raised.
- R6: A write with bit 3 set enables the watchdog without any unlock. Counting starts from zero.
- R7: A write with bit 3 clear has no effect on the enable bit while the unlock bit (bit 4) is low.
- R8: A write with bits 4 and 3 both set arms the unlock. A bit-3-clear write in any of the four following cycles disables the watchdog and drops the unlock. The same write in the fifth cycle is refused.
- R9: The unlock bit reads as one for exactly four cycles after the arming write and then clears itself.
- R10: The read-back layout is [2:0] time-out code (written on every write), [3] enable, [4] unlock, and [7:5] always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base strobe, one cycle wide per count step |
| kick_i | input | 1 | Clears the watchdog count |
| wr_i | input | 1 | Control register write strobe |
| wdata_i | input | 8 | Control register write data |
| ctrl_o | output | 8 | Control register read-back |
| wdt_rst_o | output | 1 | One-cycle system reset request |

## Verification
The checker assumes that write data is valid whenever the write strobe is high. It also assumes that the unlock span is judged from arming writes seen at the inputs, so a re-arm is allowed to restart the four-cycle span. The stimulus changes inputs only between clock edges. It shapes the strobe by hand, so expected time-outs are exact cycle counts with no phase ambiguity. The bench instance uses a small base exponent, so that every time-out code can be walked out in full.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CTRL_W  = 8;
  localparam int PSEL_W  = 3;
  localparam int EN_BIT  = 3;
  localparam int ULK_BIT = 4;
  localparam int N_CODES = 1 << PSEL_W;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int WIN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ULK_BIT:0]  wdata_i,
  output logic              en_o,
  output logic              ulk_o,
  output logic [PSEL_W-1:0] psel_o
);
  localparam int WIN_W = $clog2(WIN + 1);

  logic             en_q;
  logic [PSEL_W-1:0] psel_q;
  logic [WIN_W-1:0] win_q;
  logic             arm;
  logic             ulk;

  assign ulk = (win_q != '0);
  assign arm = wr_i && wdata_i[ULK_BIT] && wdata_i[EN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      psel_q <= '0;
      win_q  <= '0;
    end else begin
      if (wr_i) begin
        psel_q <= wdata_i[PSEL_W-1:0];
        if (wdata_i[EN_BIT]) en_q <= 1'b1;
        else if (ulk)        en_q <= 1'b0;
      end
      // unlock window: armed by both bits, consumed by an accepted disable
      if (arm)                               win_q <= WIN_W'(WIN);
      else if (wr_i && !wdata_i[EN_BIT] && ulk) win_q <= '0;
      else if (ulk)                          win_q <= win_q - 1'b1;
    end
  end

  assign en_o   = en_q;
  assign ulk_o  = ulk;
  assign psel_o = psel_q;
endmodule

// File: rtl/wdt_term.sv
module wdt_term
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 14,
  parameter int CNT_W     = BASE_LOG2 + N_CODES
) (
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [PSEL_W-1:0] psel_i,
  output logic              term_o
);
  logic [N_CODES-1:0] hit;

  for (genvar g = 0; g < N_CODES; g++) begin : g_code
    localparam logic [CNT_W-1:0] LAST = (CNT_W'(1) << (BASE_LOG2 + g)) - CNT_W'(1);
    // >= so a shortened time-out still terminates on a count already past it
    assign hit[g] = (cnt_i >= LAST);
  end

  assign term_o = hit[psel_i];
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int CNT_W = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic             term_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             fire_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (!en_i || kick_i) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (term_i) begin
          cnt_q  <= '0;
          fire_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign fire_o = fire_q;
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 14,
  parameter int WIN       = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              kick_i,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              wdt_rst_o
);
  localparam int CNT_W = BASE_LOG2 + N_CODES;

  logic              en;
  logic              ulk;
  logic [PSEL_W-1:0] psel;
  logic [CNT_W-1:0]  cnt;
  logic              term;
  logic              unused_rsvd;

  assign unused_rsvd = ^wdata_i[CTRL_W-1:ULK_BIT+1];

  wdt_ctrl #(.WIN(WIN)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .wdata_i (wdata_i[ULK_BIT:0]),
    .en_o    (en),
    .ulk_o   (ulk),
    .psel_o  (psel)
  );

  wdt_term #(.BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W)) u_term (
    .cnt_i  (cnt),
    .psel_i (psel),
    .term_o (term)
  );

  wdt_count #(.CNT_W(CNT_W)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .tick_i (tick_i),
    .kick_i (kick_i),
    .term_i (term),
    .cnt_o  (cnt),
    .fire_o (wdt_rst_o)
  );

  assign ctrl_o = {{(CTRL_W-ULK_BIT-1){1'b0}}, ulk, en, psel};
endmodule

// File: rtl/wdt_core_chk.sv
module wdt_core_chk #(
  parameter int WIN = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       kick_i,
  input logic       wr_i,
  input logic [1:0] arm_bits_i,
  input logic       en_i,
  input logic       ulk_i,
  input logic       wdt_rst_o
);
  logic [7:0] ulk_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ulk_run <= '0;
    else if (wr_i && &arm_bits_i)    ulk_run <= '0;
    else if (ulk_i && ulk_run != '1) ulk_run <= ulk_run + 1'b1;
    else if (!ulk_i)                 ulk_run <= '0;
  end

  AST_RST_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o); // R4
  AST_KICK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> !wdt_rst_o); // R3
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !wdt_rst_o); // R5
  AST_EN_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_i) |-> $past(ulk_i)); // R7
  AST_UNLOCK_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ulk_i |-> (ulk_run < 8'(WIN))); // R9
endmodule

bind wdt_core wdt_core_chk #(.WIN(WIN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .kick_i     (kick_i),
  .wr_i       (wr_i),
  .arm_bits_i (wdata_i[4:3]),
  .en_i       (ctrl_o[3]),
  .ulk_i      (ctrl_o[4]),
  .wdt_rst_o  (wdt_rst_o)
);

// File: tb/wdt_core_test.sv
module wdt_core_test;
  localparam int B  = 2;
  localparam int NV = 10;
  // time-out code, strobe divider, expected cycles to reset request (R2)
  localparam int VP[NV] = '{0, 1, 2, 3, 4, 5, 6, 7, 0, 3};
  localparam int VD[NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 2, 3};
  localparam int VE[NV] = '{4, 8, 16, 32, 64, 128, 256, 512, 8, 96};

  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b1, kick = 1'b0, wr = 1'b0;
  logic [7:0] wd = 8'h00;
  wire  [7:0] ctrl;
  wire        wrst;
  int total = 0, bad = 0;
  bit done = 1'b0;

  wdt_core #(.BASE_LOG2(B), .WIN(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .kick_i(kick),
    .wr_i(wr), .wdata_i(wd), .ctrl_o(ctrl), .wdt_rst_o(wrst)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [7:0] d);
    wr = 1'b1; wd = d; @(negedge clk); wr = 1'b0;
  endtask

  task automatic do_kick();
    kick = 1'b1; @(negedge clk); kick = 1'b0;
  endtask

  task automatic measure(input int div, input int lim, output int j);
    bit fired = 1'b0;
    do_kick();
    j = 0;
    while (j < lim && !fired) begin
      tick = ((j + 1) % div == 0);
      @(negedge clk);
      j++;
      if (wrst) fired = 1'b1;
    end
    tick = 1'b1;
    if (!fired) j = -1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int j;
    repeat (3) @(negedge clk);
    chk(ctrl == 8'h00, "R1 ctrl in reset", ctrl, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ctrl == 8'h00, "R1 ctrl after reset", ctrl, 0);
    chk(!wrst, "R1 rst_o low", wrst, 0);

    for (int i = 0; i < NV; i++) begin
      wreg(8'h08 | 8'(VP[i]));
      measure(VD[i], VE[i] + 5, j);
      chk(j == VE[i], "R2 time-out length", j, VE[i]);
    end

    // R4 single pulse and restart
    wreg(8'h08);
    measure(1, 10, j);
    chk(j == 4, "R4 first request", j, 4);
    @(negedge clk);
    chk(!wrst, "R4 pulse one cycle", wrst, 0);
    repeat (2) @(negedge clk);
    chk(!wrst, "R4 no early repeat", wrst, 0);
    @(negedge clk);
    chk(wrst, "R4 next request after full period", wrst, 1);

    // R3 kick mid-count
    wreg(8'h09);
    do_kick();
    repeat (5) @(negedge clk);
    do_kick();
    repeat (7) @(negedge clk);
    chk(!wrst, "R3 kick restarts count", wrst, 0);
    @(negedge clk);
    chk(wrst, "R3 request one period after kick", wrst, 1);

    // R3 kick on terminal strobe
    do_kick();
    repeat (7) @(negedge clk);
    do_kick();
    chk(!wrst, "R3 kick on terminal suppresses", wrst, 0);
    repeat (7) @(negedge clk);
    chk(!wrst, "R3 no early request", wrst, 0);
    @(negedge clk);
    chk(wrst, "R3 request after restart", wrst, 1);

    // R7 clear without unlock
    wreg(8'h01);
    chk(ctrl == 8'h09, "R7 disable refused", ctrl, 8'h09);

    // R10 layout, R9 self-clear
    wreg(8'hF9);
    chk(ctrl == 8'h19, "R10 reserved read zero", ctrl, 8'h19);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(ctrl[4], "R9 unlock held", ctrl[4], 1);
    end
    @(negedge clk);
    chk(!ctrl[4], "R9 unlock cleared after four", ctrl[4], 0);
    chk(ctrl[3], "R9 enable kept", ctrl[3], 1);

    // R8 window edges
    wreg(8'h19);
    repeat (3) @(negedge clk);
    wreg(8'h01);
    chk(ctrl == 8'h01, "R8 disable on fourth cycle", ctrl, 8'h01);
    wreg(8'h19);
    repeat (4) @(negedge clk);
    wreg(8'h01);
    chk(ctrl == 8'h09, "R8 disable on fifth refused", ctrl, 8'h09);
    wreg(8'h19);
    wreg(8'h00);
    chk(ctrl == 8'h00, "R8 disable on first cycle", ctrl, 0);

    // R5 disabled stays quiet
    begin
      int seen = 0;
      for (int k = 0; k < 200; k++) begin
        @(negedge clk);
        if (wrst) seen++;
      end
      chk(seen == 0, "R5 no request while disabled", seen, 0);
    end

    // R6 enable without unlock, count from zero
    wreg(8'h08);
    chk(ctrl == 8'h08, "R6 enable accepted", ctrl, 8'h08);
    repeat (3) @(negedge clk);
    chk(!wrst, "R6 no early request", wrst, 0);
    @(negedge clk);
    chk(wrst, "R6 request from zero", wrst, 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule